// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one timer channel that is driven by a free-running timebase supplied from outside. A 7-bit mode field, written by software, selects what the channel does. It can act as a plain input whose edges raise a flag, or as a plain output that software drives directly. It can latch the timebase on a single input edge, or toggle its output pin when the timebase equals one of two compare registers. It can also measure an input pulse width or an input period by latching the timebase into two registers.

A polarity bit sits next to the mode field, and its meaning depends on the mode. In the capture modes it selects which input edge counts. In compare mode it selects which register sets the pin and which clears it, and it also fixes the pin level when the mode is entered. In modes where it has no role it does nothing.

Software uses a single write strobe with a register selector, plus a write-one-to-clear strobe for the flag. The pin input passes through a synchroniser before any edge is detected.

Top module: `tmr_channel`

## Requirements
- R1: After reset the mode is 0000000 and the polarity is 0. The pin output, the flag and both compare/capture registers are 0.
- R2: Writes use `reg_sel` to pick the target. Value 0 is control: `reg_wdata[6:0]` is the mode and `reg_wdata[7]` the polarity. Value 1 is register A, value 2 is register B, and value 3 is the output data bit in `reg_wdata[0]`. A control write clears the flag and restarts any two-edge measurement.
- R3: The pin passes through two synchroniser flops. `gpi_level` shows a pin change two cycles later. An edge detected on the pin takes effect (capture or flag) in the third cycle after the pin changes. The captured timebase is the value present two cycles after the pin change.
- R4: In mode 0000000 (general input), a qualifying edge sets the flag. Polarity 1 makes rising edges qualify; polarity 0 makes falling edges qualify. The other edge does nothing.
- R5: In mode 0000001 (general output), `pin_out` follows the output data bit one cycle after it is written. Polarity has no effect on the pin in this mode.
- R6: In mode 0000010 (single capture), the first qualifying edge copies the timebase into A and sets the flag. Further edges leave A unchanged until the flag is cleared.
- R7: Writing mode 0000011 (output compare) drives `pin_out` to the inverse of the written polarity in the next cycle.
- R8: In mode 0000011, when the timebase equals A, `pin_out` takes the polarity value and the flag is set. When the timebase equals B, `pin_out` takes the inverse of the polarity. If A and B match in the same cycle, A wins. Each effect appears one cycle after the match.
- R9: In mode 0000100 (pulse width), the qualifying (leading) edge captures into A. The next opposite (trailing) edge captures into B and sets the flag. The flag does not rise on the leading edge.
- R10: In mode 0000101 (period), the first qualifying edge captures into A. The next qualifying edge captures into B and sets the flag. Opposite edges are ignored.
- R11: A `flag_clr` pulse clears the flag in the next cycle. If a flag-setting event happens in the same cycle as the clear, the flag stays set.
- R12: Any other mode code makes `pin_out` 0 and sets no flag on edges, whatever the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase | input | W | Free-running timebase value |
| pin_in | input | 1 | Asynchronous channel input pin |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector (0 control, 1 A, 2 B, 3 output data) |
| reg_wdata | input | W | Write data |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| pin_out | output | 1 | Channel output pin |
| flag | output | 1 | Event flag |
| gpi_level | output | 1 | Synchronised level of the input pin |
| ch_a | output | W | Compare/capture register A |
| ch_b | output | W | Compare/capture register B |

## Verification
The bench checks that the polarity bit is read correctly in each mode. A design that ignored polarity would capture on the wrong edge, or drive the pin the wrong way on an A match. A design that treated it as a compare-mode setting everywhere would move the pin in general-output or unused modes. It also checks the exact cycle of each capture, so an extra or missing synchroniser stage shows up as a timebase value off by one. A clear that arrives in the same cycle as an edge is checked too, since a design where the clear wins would lose that event. So are simultaneous A/B matches, where a design giving B priority would leave the pin at the wrong level. Pulse-width mode is checked to confirm the flag stays low on the leading edge, and single capture is checked to confirm later edges cannot overwrite A.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [6:0] MODE_GPI  = 7'b0000000;
    localparam logic [6:0] MODE_GPO  = 7'b0000001;
    localparam logic [6:0] MODE_SAIC = 7'b0000010;
    localparam logic [6:0] MODE_SAOC = 7'b0000011;
    localparam logic [6:0] MODE_IPWM = 7'b0000100;
    localparam logic [6:0] MODE_IPM  = 7'b0000101;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_A    = 2'd1,
        SEL_B    = 2'd2,
        SEL_DOUT = 2'd3
    } sel_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_ARMED = 1'b1
    } phase_e;

    // edges already mapped through the polarity bit
    typedef struct packed {
        logic lead;   // edge selected by polarity
        logic trail;  // opposite edge
    } edge_evt_t;

    function automatic edge_evt_t map_edges(input logic pol, input logic rise, input logic fall);
        edge_evt_t e;
        e.lead  = pol ? rise : fall;
        e.trail = pol ? fall : rise;
        return e;
    endfunction

endpackage

// File: rtl/tmr_edge_sense.sv
module tmr_edge_sense
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  logic      pol,
    output logic      level,
    output edge_evt_t evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level = sync_q[SYNC_STAGES-1];
    assign evt   = map_edges(pol, level & ~prev_q, ~level & prev_q);

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [6:0]   mode,
    input  edge_evt_t    evt,
    input  logic [W-1:0] tbase,
    input  logic         flag,
    input  logic         restart,
    input  logic         sw_wr_a,
    input  logic         sw_wr_b,
    input  logic [W-1:0] sw_data,
    output logic [W-1:0] reg_a,
    output logic [W-1:0] reg_b,
    output logic         cap_set
);
    phase_e phase_q, phase_d;
    logic   cap_a, cap_b;

    always_comb begin
        cap_a   = 1'b0;
        cap_b   = 1'b0;
        cap_set = 1'b0;
        phase_d = phase_q;
        case (mode)
            MODE_GPI: cap_set = evt.lead;
            MODE_SAIC: begin
                if (evt.lead && !flag) begin
                    cap_a   = 1'b1;
                    cap_set = 1'b1;
                end
            end
            MODE_IPWM: begin
                if (phase_q == PH_IDLE && evt.lead) begin
                    cap_a   = 1'b1;
                    phase_d = PH_ARMED;
                end else if (phase_q == PH_ARMED && evt.trail) begin
                    cap_b   = 1'b1;
                    cap_set = 1'b1;
                    phase_d = PH_IDLE;
                end
            end
            MODE_IPM: begin
                if (evt.lead) begin
                    if (phase_q == PH_IDLE) begin
                        cap_a   = 1'b1;
                        phase_d = PH_ARMED;
                    end else begin
                        cap_b   = 1'b1;
                        cap_set = 1'b1;
                        phase_d = PH_IDLE;
                    end
                end
            end
            default: ;
        endcase
        if (restart) phase_d = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            reg_a   <= '0;
            reg_b   <= '0;
        end else begin
            phase_q <= phase_d;
            if (cap_a)        reg_a <= tbase;
            else if (sw_wr_a) reg_a <= sw_data;
            if (cap_b)        reg_b <= tbase;
            else if (sw_wr_b) reg_b <= sw_data;
        end
    end

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         enter,
    input  logic         enter_pol,
    input  logic         pol,
    input  logic [W-1:0] tbase,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] reg_b,
    output logic         out_q,
    output logic         match_a
);
    logic match_b;

    assign match_a = active && (tbase == reg_a);
    assign match_b = active && (tbase == reg_b);

    always_ff @(posedge clk) begin
        if (rst)          out_q <= 1'b0;
        else if (enter)   out_q <= ~enter_pol;
        else if (match_a) out_q <= pol;
        else if (match_b) out_q <= ~pol;
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tbase,
    input  logic         pin_in,
    input  logic         reg_we,
    input  logic [1:0]   reg_sel,
    input  logic [W-1:0] reg_wdata,
    input  logic         flag_clr,
    output logic         pin_out,
    output logic         flag,
    output logic         gpi_level,
    output logic [W-1:0] ch_a,
    output logic [W-1:0] ch_b
);
    localparam int MODE_W = 7;

    logic [MODE_W-1:0] mode_q;
    logic              pol_q;
    logic              dout_q;
    logic              flag_q;
    edge_evt_t         evt;
    logic              wr_ctrl, wr_a, wr_b, wr_dout;
    logic              cap_set, match_a, oc_out;

    assign wr_ctrl = reg_we && (sel_e'(reg_sel) == SEL_CTRL);
    assign wr_a    = reg_we && (sel_e'(reg_sel) == SEL_A);
    assign wr_b    = reg_we && (sel_e'(reg_sel) == SEL_B);
    assign wr_dout = reg_we && (sel_e'(reg_sel) == SEL_DOUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_GPI;
            pol_q  <= 1'b0;
            dout_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= reg_wdata[MODE_W-1:0];
                pol_q  <= reg_wdata[MODE_W];
            end
            if (wr_dout) dout_q <= reg_wdata[0];
        end
    end

    tmr_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin   (pin_in),
        .pol   (pol_q),
        .level (gpi_level),
        .evt   (evt)
    );

    tmr_capture #(.W(W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_q),
        .evt     (evt),
        .tbase   (tbase),
        .flag    (flag_q),
        .restart (wr_ctrl),
        .sw_wr_a (wr_a),
        .sw_wr_b (wr_b),
        .sw_data (reg_wdata),
        .reg_a   (ch_a),
        .reg_b   (ch_b),
        .cap_set (cap_set)
    );

    tmr_compare #(.W(W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .active    (mode_q == MODE_SAOC),
        .enter     (wr_ctrl && (reg_wdata[MODE_W-1:0] == MODE_SAOC)),
        .enter_pol (reg_wdata[MODE_W]),
        .pol       (pol_q),
        .tbase     (tbase),
        .reg_a     (ch_a),
        .reg_b     (ch_b),
        .out_q     (oc_out),
        .match_a   (match_a)
    );

    // mode write first, then events, then software clear
    always_ff @(posedge clk) begin
        if (rst)                    flag_q <= 1'b0;
        else if (wr_ctrl)           flag_q <= 1'b0;
        else if (cap_set | match_a) flag_q <= 1'b1;
        else if (flag_clr)          flag_q <= 1'b0;
    end

    assign flag = flag_q;

    always_comb begin
        case (mode_q)
            MODE_GPO:  pin_out = dout_q;
            MODE_SAOC: pin_out = oc_out;
            default:   pin_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_we,
    input logic [1:0]   reg_sel,
    input logic [W-1:0] reg_wdata,
    input logic         flag_clr,
    input logic [W-1:0] tbase,
    input logic         pin_out,
    input logic         flag,
    input logic [W-1:0] ch_a,
    input logic [6:0]   mode_q,
    input logic         pol_q
);
    AST_ENTRY_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == 2'd0 && reg_wdata[6:0] == 7'b0000011)
        |=> (pin_out == !$past(reg_wdata[7]))); // R7

    AST_GPO_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == 2'd3 && mode_q == 7'b0000001)
        |=> (pin_out == $past(reg_wdata[0]))); // R5

    AST_SAIC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 7'b0000010 && flag && !flag_clr && !reg_we)
        |=> $stable(ch_a)); // R6

    AST_OC_A_MATCH: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 7'b0000011 && tbase == ch_a && !reg_we)
        |=> (pin_out == $past(pol_q) && flag)); // R8

    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 7'b0000011 && flag_clr && !reg_we && tbase != ch_a)
        |=> !flag); // R11

    AST_UNUSED_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 7'b0000110 && !reg_we) |=> (pin_out == 1'b0 && !$rose(flag))); // R12

endmodule

bind tmr_channel tmr_channel_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .flag_clr  (flag_clr),
    .tbase     (tbase),
    .pin_out   (pin_out),
    .flag      (flag),
    .ch_a      (ch_a),
    .mode_q    (mode_q),
    .pol_q     (pol_q)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
    localparam int W = 16;
    localparam int SIG_PIN = 0, SIG_FLAG = 1, SIG_A = 2, SIG_B = 3, SIG_GPI = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pin_in = 1'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_sel = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic         flag_clr = 1'b0;
    logic         pin_out, flag, gpi_level;
    logic [W-1:0] ch_a, ch_b;
    int           cyc = 0;
    logic [W-1:0] tbase;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        int    when;
        int    sig;
        int    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign tbase = cyc[W-1:0];

    tmr_channel #(.W(W)) i_tmr_channel (
        .clk       (clk),
        .rst       (rst),
        .tbase     (tbase),
        .pin_in    (pin_in),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .flag_clr  (flag_clr),
        .pin_out   (pin_out),
        .flag      (flag),
        .gpi_level (gpi_level),
        .ch_a      (ch_a),
        .ch_b      (ch_b)
    );

    function automatic int actual(int sig);
        case (sig)
            SIG_PIN:  return int'(pin_out);
            SIG_FLAG: return int'(flag);
            SIG_A:    return int'(ch_a);
            SIG_B:    return int'(ch_b);
            default:  return int'(gpi_level);
        endcase
    endfunction

    // monitor: pops every expectation due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].when == cyc) begin
                tests++;
                if (actual(sb[i].sig) != sb[i].val) begin
                    fails++;
                    $display("FAIL %s: cycle %0d signal %0d actual %0d expected %0d",
                             sb[i].tag, cyc, sb[i].sig, actual(sb[i].sig), sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic ctrl(input logic [6:0] m, input logic p);
        wr(2'd0, W'({p, m}));
    endtask

    task automatic clr();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    task automatic push_at(input int when, input int sig, input int val, input string tag);
        exp_t e;
        e.when = when; e.sig = sig; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic exp_in(input int off, input int sig, input int val, input string tag);
        push_at(cyc + off, sig, val, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic wait_until(input int when);
        while (cyc < when) tick();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running, expected finished");
            finish_run();
        end
    end

    initial begin
        int t, c;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        exp_in(0, SIG_PIN, 0, "R1");
        exp_in(0, SIG_FLAG, 0, "R1");
        exp_in(0, SIG_A, 0, "R1");
        exp_in(0, SIG_B, 0, "R1");
        idle(2);

        // general input, rising edges qualify: R3 R4
        ctrl(7'b0000000, 1'b1);
        pin_in = 1'b1;
        exp_in(1, SIG_GPI, 0, "R3");
        exp_in(2, SIG_GPI, 1, "R3");
        exp_in(2, SIG_FLAG, 0, "R3");
        exp_in(3, SIG_FLAG, 1, "R4");
        idle(5);
        clr();
        exp_in(0, SIG_FLAG, 0, "R11");
        pin_in = 1'b0;                 // falling edge: must not qualify
        exp_in(3, SIG_FLAG, 0, "R4");
        exp_in(5, SIG_FLAG, 0, "R4");
        idle(6);
        // clear collides with a qualifying edge: R11
        pin_in = 1'b1;
        idle(2);
        clr();
        exp_in(0, SIG_FLAG, 1, "R11");
        idle(2);
        clr();
        exp_in(0, SIG_FLAG, 0, "R11");
        pin_in = 1'b0;
        idle(4);

        // general output: R5
        ctrl(7'b0000001, 1'b1);
        wr(2'd3, 16'd1);
        exp_in(0, SIG_PIN, 1, "R5");
        wr(2'd3, 16'd0);
        exp_in(0, SIG_PIN, 0, "R5");
        wr(2'd3, 16'd1);
        ctrl(7'b0000001, 1'b0);
        exp_in(0, SIG_PIN, 1, "R5");
        idle(2);

        // output compare, polarity 0: R7 R8
        wr(2'd1, 16'hF000);
        wr(2'd2, 16'hF000);
        ctrl(7'b0000011, 1'b0);
        exp_in(0, SIG_PIN, 1, "R7");
        t = cyc + 6;
        wr(2'd1, W'(t));
        push_at(t, SIG_PIN, 1, "R8");
        push_at(t + 1, SIG_PIN, 0, "R8");
        push_at(t + 1, SIG_FLAG, 1, "R8");
        wait_until(t + 2);
        t = cyc + 6;
        wr(2'd2, W'(t));
        push_at(t + 1, SIG_PIN, 1, "R8");
        wait_until(t + 2);
        clr();
        exp_in(0, SIG_FLAG, 0, "R11");

        // output compare, polarity 1, A and B match together
        ctrl(7'b0000011, 1'b1);
        exp_in(0, SIG_PIN, 0, "R7");
        t = cyc + 8;
        wr(2'd1, W'(t));
        wr(2'd2, W'(t));
        push_at(t, SIG_PIN, 0, "R8");
        push_at(t + 1, SIG_PIN, 1, "R8");
        push_at(t + 1, SIG_FLAG, 1, "R8");
        wait_until(t + 2);
        t = cyc + 6;
        wr(2'd2, W'(t));
        push_at(t + 1, SIG_PIN, 0, "R8");
        wait_until(t + 2);

        // pulse width, polarity 1: R9 (flag set above must be cleared by mode write, R2)
        ctrl(7'b0000100, 1'b1);
        exp_in(0, SIG_FLAG, 0, "R2");
        exp_in(0, SIG_PIN, 0, "R12");
        idle(2);
        c = cyc; pin_in = 1'b1;
        push_at(c + 3, SIG_A, c + 2, "R9");
        push_at(c + 3, SIG_FLAG, 0, "R9");
        idle(6);
        c = cyc; pin_in = 1'b0;
        push_at(c + 2, SIG_FLAG, 0, "R9");
        push_at(c + 3, SIG_B, c + 2, "R9");
        push_at(c + 3, SIG_FLAG, 1, "R9");
        idle(6);

        // period, polarity 0 (falling edges qualify): R10
        ctrl(7'b0000101, 1'b0);
        exp_in(0, SIG_FLAG, 0, "R2");
        pin_in = 1'b1;
        idle(5);
        c = cyc; pin_in = 1'b0;
        push_at(c + 3, SIG_A, c + 2, "R10");
        idle(5);
        pin_in = 1'b1;
        exp_in(3, SIG_FLAG, 0, "R10");
        idle(5);
        c = cyc; pin_in = 1'b0;
        push_at(c + 2, SIG_FLAG, 0, "R10");
        push_at(c + 3, SIG_B, c + 2, "R10");
        push_at(c + 3, SIG_FLAG, 1, "R10");
        idle(6);

        // single capture, polarity 0: R6
        ctrl(7'b0000010, 1'b0);
        pin_in = 1'b1;
        idle(5);
        c = cyc; pin_in = 1'b0;
        push_at(c + 3, SIG_A, c + 2, "R6");
        push_at(c + 3, SIG_FLAG, 1, "R6");
        idle(5);
        pin_in = 1'b1;
        idle(5);
        pin_in = 1'b0;
        exp_in(4, SIG_A, c + 2, "R6");
        idle(6);
        clr();
        pin_in = 1'b1;
        idle(5);
        c = cyc; pin_in = 1'b0;
        push_at(c + 3, SIG_A, c + 2, "R6");
        idle(6);

        // unused mode code with polarity 1: R12
        ctrl(7'b0000110, 1'b1);
        exp_in(0, SIG_PIN, 0, "R12");
        exp_in(0, SIG_FLAG, 0, "R2");
        pin_in = 1'b1;
        exp_in(4, SIG_FLAG, 0, "R12");
        exp_in(4, SIG_PIN, 0, "R12");
        idle(5);
        pin_in = 1'b0;
        exp_in(4, SIG_FLAG, 0, "R12");
        idle(8);

        foreach (sb[i]) begin
            fails++;
            $display("FAIL %s: expectation for cycle %0d never checked, actual none expected %0d",
                     sb[i].tag, sb[i].when, sb[i].val);
        end
        done = 1'b1;
        finish_run();
    end

endmodule